// File: doc/BRIEF.md
# DMA Page Register File

This block holds the page registers that widen a 16-bit DMA channel address into a 31-bit physical address. It serves four channels. Each channel owns an 8-bit low page register and an 8-bit high page register. Software reaches them through a byte-wide register port. The port carries a 3-bit offset and a bank select that picks the low bank or the high bank. Both banks decode the offset in the same way. The offset-to-channel map is irregular, and four of the eight offsets reach no channel.

Apart from the register port, the block builds the physical address for one channel, chosen by `sel_chan`. It places bits 6:0 of that channel's high page above its low page, and puts the channel's current 16-bit address below them. Bit 7 of the high page is kept and can be read back, but it never reaches the address. A configuration input switches the high bank off. While it is off, the high bank does not decode and the high field of the address is zero.

An access is a single-cycle request with no back-pressure, because the register file can always take one. A read answers one cycle later on `rd_valid`/`rd_data`, and this answer cannot be stalled. An access to a location that maps to nothing raises `err` for one cycle.

Top module: `pgreg_file`

## Requirements
- R1: After reset, every low and high page register reads 0, and `phys_addr[30:16]` is 0 for every channel.
- R2: A low-bank write (`req_high`=0) updates one channel's low page. Offset 1 selects channel 2, offset 2 selects channel 3, offset 3 selects channel 1 and offset 7 selects channel 0.
- R3: A read request is answered in the following cycle. That cycle has `rd_valid`=1 and `rd_data` equal to the addressed register. `rd_valid` is 0 after a write or an idle cycle.
- R4: While `hi_en`=1, a high-bank access (`req_high`=1) uses the same offset map and writes or reads all 8 bits of that channel's high page.
- R5: In the same cycle, `phys_addr` equals {high page bits 6:0, low page, `cur_addr`} of channel `sel_chan`. Bit 30 is high page bit 6, bits 23:16 are the low page, and bits 15:0 are `cur_addr`. High page bit 7 never reaches the address.
- R6: A write to offset 0, 4, 5 or 6 changes no register. A read from one of these offsets returns 0xFF.
- R7: `err` is 1 for exactly the one cycle that follows any access, read or write, that maps to no register. It is 0 after mapped accesses and idle cycles.
- R8: While `hi_en`=0, a high-bank access counts as unmapped. The write is ignored, a read returns 0xFF, and `err` pulses. `phys_addr[30:24]` is 0 during this time. The high page contents are kept, and they show again once `hi_en` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hi_en | input | 1 | Enables the high page bank |
| req_valid | input | 1 | Register access in this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_high | input | 1 | 1 = high page bank, 0 = low page bank |
| req_off | input | 3 | Register offset |
| req_wdata | input | 8 | Write data |
| rd_valid | output | 1 | Read answer valid |
| rd_data | output | 8 | Read answer data |
| err | output | 1 | One-cycle pulse after an unmapped access |
| sel_chan | input | 2 | Channel whose address is built |
| cur_addr | input | 16 | Current 16-bit address of that channel |
| phys_addr | output | 31 | Composed physical address |

## Verification
The bench builds the block with its default parameters: 8-bit pages, a 16-bit channel address and 7 high page bits in use, which gives the 31-bit address. It writes values that have bit 7 set into the high bank, which shows that the top high page bit is kept for reads and dropped from the address. It uses distinct values per channel, so that any error in the irregular offset map appears in the address. It also turns `hi_en` off and back on around high-bank writes, which covers both the ignored writes and the retention of earlier contents.

// File: rtl/pgreg_pkg.sv
package pgreg_pkg;
  localparam int NUM_CH = 4;
  localparam int CH_W   = $clog2(NUM_CH);
  localparam int OFF_W  = 3;

  typedef struct packed {
    logic            hit;
    logic [CH_W-1:0] ch;
  } chan_sel_t;

  // Offsets 1,2,3,7 reach channels 2,3,1,0; others reach nothing.
  function automatic chan_sel_t map_offset(input logic [OFF_W-1:0] off);
    chan_sel_t s;
    s = '{hit: 1'b0, ch: '0};
    case (off)
      3'd1: s = '{hit: 1'b1, ch: CH_W'(2)};
      3'd2: s = '{hit: 1'b1, ch: CH_W'(3)};
      3'd3: s = '{hit: 1'b1, ch: CH_W'(1)};
      3'd7: s = '{hit: 1'b1, ch: CH_W'(0)};
      default: s = '{hit: 1'b0, ch: '0};
    endcase
    return s;
  endfunction
endpackage

// File: rtl/pgreg_decode.sv
module pgreg_decode
  import pgreg_pkg::*;
(
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             req_high,
  input  logic [OFF_W-1:0] req_off,
  input  logic             hi_en,
  output logic [NUM_CH-1:0] wr_lo,
  output logic [NUM_CH-1:0] wr_hi,
  output logic             hit,
  output logic [CH_W-1:0]  ch
);
  chan_sel_t sel;

  always_comb begin
    sel   = map_offset(req_off);
    hit   = sel.hit && (!req_high || hi_en);
    ch    = sel.ch;
    wr_lo = '0;
    wr_hi = '0;
    if (req_valid && req_write && hit) begin
      if (req_high) wr_hi[ch] = 1'b1;
      else          wr_lo[ch] = 1'b1;
    end
  end
endmodule

// File: rtl/pgreg_bank.sv
module pgreg_bank #(
  parameter int PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PAGE_W-1:0] wdata,
  output logic [PAGE_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)     q <= '0;
    else if (wr_en) q <= wdata;
  end
endmodule

// File: rtl/pgreg_addr_build.sv
module pgreg_addr_build
  import pgreg_pkg::*;
#(
  parameter int PAGE_W = 8,
  parameter int ADDR_W = 16,
  parameter int HI_USE = 7,
  localparam int PHYS_W = HI_USE + PAGE_W + ADDR_W
) (
  input  logic [NUM_CH-1:0][PAGE_W-1:0] lo_pages,
  input  logic [NUM_CH-1:0][PAGE_W-1:0] hi_pages,
  input  logic                          hi_en,
  input  logic [CH_W-1:0]               sel_chan,
  input  logic [ADDR_W-1:0]             cur_addr,
  output logic [PHYS_W-1:0]             phys_addr
);
  logic [PAGE_W-1:0] hi_sel;

  always_comb begin
    hi_sel    = hi_en ? hi_pages[sel_chan] : '0;
    phys_addr = {hi_sel[HI_USE-1:0], lo_pages[sel_chan], cur_addr};
  end
endmodule

// File: rtl/pgreg_file.sv
module pgreg_file
  import pgreg_pkg::*;
#(
  parameter int          PAGE_W   = 8,
  parameter int          ADDR_W   = 16,
  parameter int          HI_USE   = 7,
  parameter logic [7:0]  BAD_READ = 8'hFF,
  localparam int         PHYS_W   = HI_USE + PAGE_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hi_en,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_high,
  input  logic [OFF_W-1:0]  req_off,
  input  logic [PAGE_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [PAGE_W-1:0] rd_data,
  output logic              err,
  input  logic [CH_W-1:0]   sel_chan,
  input  logic [ADDR_W-1:0] cur_addr,
  output logic [PHYS_W-1:0] phys_addr
);
  logic [NUM_CH-1:0]             wr_lo, wr_hi;
  logic                          hit;
  logic [CH_W-1:0]               ch;
  logic [NUM_CH-1:0][PAGE_W-1:0] lo_pages, hi_pages;
  logic [PAGE_W-1:0]             rd_next;

  pgreg_decode dec_i (
    .req_valid(req_valid), .req_write(req_write), .req_high(req_high),
    .req_off(req_off), .hi_en(hi_en),
    .wr_lo(wr_lo), .wr_hi(wr_hi), .hit(hit), .ch(ch)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    pgreg_bank #(.PAGE_W(PAGE_W)) lo_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_lo[g]),
      .wdata(req_wdata), .q(lo_pages[g])
    );
    pgreg_bank #(.PAGE_W(PAGE_W)) hi_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_hi[g]),
      .wdata(req_wdata), .q(hi_pages[g])
    );
  end

  always_comb begin
    if (!hit)          rd_next = PAGE_W'(BAD_READ);
    else if (req_high) rd_next = hi_pages[ch];
    else               rd_next = lo_pages[ch];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      err      <= 1'b0;
    end else begin
      rd_valid <= req_valid && !req_write;
      err      <= req_valid && !hit;
      if (req_valid && !req_write) rd_data <= rd_next;
    end
  end

  pgreg_addr_build #(.PAGE_W(PAGE_W), .ADDR_W(ADDR_W), .HI_USE(HI_USE)) addr_i (
    .lo_pages(lo_pages), .hi_pages(hi_pages), .hi_en(hi_en),
    .sel_chan(sel_chan), .cur_addr(cur_addr), .phys_addr(phys_addr)
  );
endmodule

// File: rtl/pgreg_file_chk.sv
module pgreg_file_chk
  import pgreg_pkg::*;
#(
  parameter int         PAGE_W   = 8,
  parameter int         ADDR_W   = 16,
  parameter int         HI_USE   = 7,
  parameter logic [7:0] BAD_READ = 8'hFF,
  localparam int        PHYS_W   = HI_USE + PAGE_W + ADDR_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hi_en,
  input logic              req_valid,
  input logic              req_write,
  input logic              req_high,
  input logic [OFF_W-1:0]  req_off,
  input logic              rd_valid,
  input logic [PAGE_W-1:0] rd_data,
  input logic              err,
  input logic [CH_W-1:0]   sel_chan,
  input logic [PHYS_W-1:0] phys_addr
);
  logic unmapped;
  always_comb begin
    unmapped = !map_offset(req_off).hit || (req_high && !hi_en);
  end

  a_r3_answer_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(req_valid && !req_write));

  a_r6_bad_read_value: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && err) |-> rd_data == PAGE_W'(BAD_READ));

  a_r6_bad_write_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && unmapped) ##1 ($stable(sel_chan) && $stable(hi_en))
      |-> $stable(phys_addr[PHYS_W-1:ADDR_W]));

  a_r7_err_raised: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && unmapped) |=> err);

  a_r7_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(req_valid));

  a_r8_high_field_off: assert property (@(posedge clk) disable iff (!rst_n)
    !hi_en |-> phys_addr[PHYS_W-1:PAGE_W+ADDR_W] == '0);
endmodule

bind pgreg_file pgreg_file_chk #(
  .PAGE_W(PAGE_W), .ADDR_W(ADDR_W), .HI_USE(HI_USE), .BAD_READ(BAD_READ)
) chk_i (
  .clk(clk), .rst_n(rst_n), .hi_en(hi_en), .req_valid(req_valid),
  .req_write(req_write), .req_high(req_high), .req_off(req_off),
  .rd_valid(rd_valid), .rd_data(rd_data), .err(err),
  .sel_chan(sel_chan), .phys_addr(phys_addr)
);

// File: tb/pgreg_file_tb_top.sv
module pgreg_file_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hi_en = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0, req_high = 1'b0;
  logic [2:0]  req_off = '0;
  logic [7:0]  req_wdata = '0;
  logic        rd_valid, err;
  logic [7:0]  rd_data;
  logic [1:0]  sel_chan = '0;
  logic [15:0] cur_addr = '0;
  logic [30:0] phys_addr;

  int checks = 0, errors = 0;
  logic [7:0] lo_m [4];
  logic [7:0] hi_m [4];

  always #5 clk = ~clk;

  pgreg_file dut_i (
    .clk(clk), .rst_n(rst_n), .hi_en(hi_en), .req_valid(req_valid),
    .req_write(req_write), .req_high(req_high), .req_off(req_off),
    .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data), .err(err),
    .sel_chan(sel_chan), .cur_addr(cur_addr), .phys_addr(phys_addr)
  );

  function automatic int chan_of(input logic [2:0] off);
    case (off)
      3'd7: return 0;
      3'd3: return 1;
      3'd1: return 2;
      3'd2: return 3;
      default: return -1;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic access(input logic wr, input logic hi, input logic [2:0] off,
                        input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_high = hi; req_off = off; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic idle_err_zero(input string tag);
    @(negedge clk);
    chk(tag, {31'd0, err}, 32'd0);
  endtask

  task automatic check_addr(input string tag, input int c, input logic [15:0] a);
    logic [6:0] hx;
    sel_chan = 2'(c); cur_addr = a;
    #1;
    hx = hi_en ? hi_m[c][6:0] : 7'd0;
    chk(tag, {1'b0, phys_addr}, {1'b0, hx, lo_m[c], a});
  endtask

  task automatic t_reset();
    for (int o = 0; o < 8; o++) begin
      if (chan_of(3'(o)) < 0) continue;
      access(1'b0, 1'b0, 3'(o), 8'h00);
      chk("R1 low read", {23'd0, rd_valid, rd_data}, {23'd0, 1'b1, 8'h00});
      access(1'b0, 1'b1, 3'(o), 8'h00);
      chk("R1 high read", {24'd0, rd_data}, 32'd0);
    end
    for (int c = 0; c < 4; c++) check_addr("R1 reset addr", c, 16'h0000);
  endtask

  task automatic t_low_map();
    logic [2:0] offs [4] = '{3'd7, 3'd3, 3'd1, 3'd2};
    for (int i = 0; i < 4; i++) begin
      access(1'b1, 1'b0, offs[i], 8'h10 + 8'(i * 17));
      lo_m[chan_of(offs[i])] = 8'h10 + 8'(i * 17);
      chk("R3 no answer on write", {30'd0, rd_valid, err}, 32'd0);
    end
    for (int c = 0; c < 4; c++) check_addr("R2 low map", c, 16'h1234 + 16'(c));
    for (int i = 0; i < 4; i++) begin
      access(1'b0, 1'b0, offs[i], 8'h00);
      chk("R3 read back", {22'd0, rd_valid, err, rd_data},
          {22'd0, 1'b1, 1'b0, lo_m[chan_of(offs[i])]});
    end
  endtask

  task automatic t_high();
    logic [2:0] offs [4] = '{3'd1, 3'd2, 3'd3, 3'd7};
    hi_en = 1'b1;
    for (int i = 0; i < 4; i++) begin
      access(1'b1, 1'b1, offs[i], 8'h85 + 8'(i * 34));
      hi_m[chan_of(offs[i])] = 8'h85 + 8'(i * 34);
    end
    for (int c = 0; c < 4; c++) check_addr("R5 full address", c, 16'hBEEF ^ 16'(c));
    check_addr("R5 cur_addr pass", 2, 16'hFFFF);
    for (int i = 0; i < 4; i++) begin
      access(1'b0, 1'b1, offs[i], 8'h00);
      chk("R4 high read 8 bits", {23'd0, rd_valid, rd_data},
          {23'd0, 1'b1, hi_m[chan_of(offs[i])]});
    end
  endtask

  task automatic t_bad();
    logic [2:0] bad [4] = '{3'd0, 3'd4, 3'd5, 3'd6};
    for (int i = 0; i < 4; i++) begin
      access(1'b1, 1'b0, bad[i], 8'hAA);
      chk("R7 err on bad write", {31'd0, err}, 32'd1);
      idle_err_zero("R7 err one cycle");
      access(1'b1, 1'b1, bad[i], 8'hAA);
      chk("R7 err on bad high write", {31'd0, err}, 32'd1);
    end
    for (int c = 0; c < 4; c++) check_addr("R6 bad write no change", c, 16'h0F0F);
    for (int i = 0; i < 4; i++) begin
      access(1'b0, 1'b0, bad[i], 8'h00);
      chk("R6 bad read FF", {22'd0, rd_valid, err, rd_data}, {22'd0, 1'b1, 1'b1, 8'hFF});
    end
    access(1'b0, 1'b0, 3'd7, 8'h00);
    chk("R7 no err on mapped", {31'd0, err}, 32'd0);
  endtask

  task automatic t_hi_off();
    hi_en = 1'b0;
    for (int c = 0; c < 4; c++) check_addr("R8 high field zero", c, 16'h5555);
    access(1'b1, 1'b1, 3'd7, 8'h11);
    chk("R8 disabled write err", {31'd0, err}, 32'd1);
    access(1'b0, 1'b1, 3'd7, 8'h00);
    chk("R8 disabled read", {23'd0, err, rd_data}, {23'd0, 1'b1, 8'hFF});
    access(1'b1, 1'b0, 3'd7, 8'h66);
    lo_m[0] = 8'h66;
    chk("R8 low bank still works", {31'd0, err}, 32'd0);
    check_addr("R8 low still composed", 0, 16'h0001);
    hi_en = 1'b1;
    access(1'b0, 1'b1, 3'd7, 8'h00);
    chk("R8 content kept", {23'd0, err, rd_data}, {23'd0, 1'b0, hi_m[0]});
    check_addr("R8 re-enabled address", 0, 16'h0002);
  endtask

  initial begin
    for (int c = 0; c < 4; c++) begin lo_m[c] = 8'h00; hi_m[c] = 8'h00; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 outputs after reset", {30'd0, rd_valid, err}, 32'd0);
    t_reset();
    t_low_map();
    t_high();
    t_bad();
    t_hi_off();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule